// File: doc/BRIEF.md
# ADC Sample-Sequencer FIFO and Trigger Unit

This block is the digital half of a four-sequencer analog-to-digital converter. Each sequencer owns a 16-entry sample queue and a pair of configuration words: an input-mux word and a control word. A set of shared registers holds the per-sequencer enables, the raw and masked interrupt state, the sticky overflow and underflow flags, the trigger-source selection, a priority word and an averaging word. The conversion itself is not modelled. Instead, an accepted trigger takes the next value from a 32-bit linear congruential noise generator and pushes a derived sample into the sequencer's queue.

Software reaches the block over a simple register bus. A write strobe takes effect on every clock edge at which it is high. A read strobe acts only on its rising edge, so a read that is held for several cycles still removes at most one sample. The read word is registered and can be seen in the cycle after the accepted edge. Each sequencer drives its own registered interrupt line.

Top module: `adcseq_top`

## Requirements
- R1: After a synchronous reset, the following hold:
  - Every queue is empty, with both pointers at 0.
  - The enable, raw, mask, overflow, underflow, event-select, priority, averaging, mux and control registers are 0.
  - The noise state is 0.
  - All interrupt lines are low.
- R2: The queue state word (window offset 0x0C) holds these fields:
  - read pointer in bits [3:0];
  - write pointer in bits [7:4];
  - full flag in bit 8;
  - empty flag in bit 9.

  All other bits read 0, and full and empty are never set together.
- R3: A trigger pulse on sequencer n is accepted only when enable bit n is set and the event-select field at bits [4n+3:4n] (register 0x014) equals 5. Any other trigger leaves the queue, the raw bits and the noise state unchanged.
- R4: Each accepted trigger first advances the noise state to noise*314159+1 (modulo 2^32). It then pushes 0x200 plus the new state's bits [18:16]. Triggers accepted in the same cycle advance the noise state in ascending sequencer order.
- R5: A read of the data word (window offset 0x08) returns the oldest sample and advances the read pointer by one, modulo 16. The empty flag is set when the read pointer reaches the write pointer.
- R6: A read strobe held high for several cycles removes exactly one sample. The read word appears on the bus in the cycle after the strobe's rising edge.
- R7: A read of an empty queue sets underflow bit n (register 0x018) and leaves the pointers and flags unchanged.
- R8: After 16 samples the queue reports full, and write pointer equals read pointer. A further accepted trigger drops its sample and sets overflow bit n (register 0x010). That trigger still sets raw bit n.
- R9: An accepted trigger sets raw bit n (register 0x004). Interrupt line n equals raw bit n AND mask bit n (register 0x008), and changes at the same clock edge as those registers. The masked status reads at 0x00C.
- R10: Writing 1s to the raw, overflow or underflow registers clears those bits. A set event in the same cycle takes precedence over the clear.
- R11: Other registers store what is written, as follows:
  - mux words keep only the bits of mask 0x33333333;
  - the enable register keeps its low 4 bits;
  - control, priority (0x020) and averaging (0x030) read back as written.
- R12: The registers of sequencer n occupy a 32-byte window at offset 0x40 + 32n, with this layout:
  - mux at +0x0;
  - control at +0x4;
  - data at +0x8;
  - state at +0xC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, acts every cycle it is high |
| bus_rd | input | 1 | Register read strobe, acts on its rising edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| trig | input | 4 | Per-sequencer trigger pulses, one per high cycle |
| irq | output | 4 | Per-sequencer registered interrupt lines |

## Verification
The assertions assume two things about the inputs:
- The internal pop request never lasts two consecutive cycles, which the read-edge detector guarantees whatever the bus does.
- A queue that is full and is written without a pop keeps its write pointer.

The stimulus drives the bus and the trigger lines only on falling edges and holds the read strobe low for at least one edge between reads, so every read is a separate rising edge. A held read is used only where the one-pop rule is itself under test. Triggers are sent singly or as deliberate same-cycle groups. The bench mirrors the enable and event-select values it wrote so that it can predict which triggers are accepted.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned EVT_CODE   = 5;
  localparam int unsigned EVT_W      = 4;
  localparam int unsigned WIN_BASE   = 'h40;
  localparam int unsigned WIN_SPAN   = 32;
  localparam int unsigned OFF_ENABLE = 'h000;
  localparam int unsigned OFF_RAW    = 'h004;
  localparam int unsigned OFF_MASK   = 'h008;
  localparam int unsigned OFF_MSTAT  = 'h00C;
  localparam int unsigned OFF_OVF    = 'h010;
  localparam int unsigned OFF_EVSEL  = 'h014;
  localparam int unsigned OFF_UNF    = 'h018;
  localparam int unsigned OFF_PRIO   = 'h020;
  localparam int unsigned OFF_AVG    = 'h030;
  localparam int unsigned SUB_MUX    = 'h0;
  localparam int unsigned SUB_CTRL   = 'h4;
  localparam int unsigned SUB_DATA   = 'h8;
  localparam int unsigned SUB_STATE  = 'hC;
  localparam logic [31:0] MUX_KEEP   = 32'h3333_3333;
  localparam logic [31:0] SAMPLE_BASE = 32'h200;

  function automatic logic [31:0] lcg_next(input logic [31:0] x);
    return x * 32'd314159 + 32'd1;
  endfunction
endpackage

// File: rtl/adcseq_fifo.sv
module adcseq_fifo #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [DATA_W-1:0]        push_data,
  input  logic                     pop,
  output logic [DATA_W-1:0]        rd_data,
  output logic [$clog2(DEPTH)-1:0] head,
  output logic [$clog2(DEPTH)-1:0] tail,
  output logic                     full,
  output logic                     empty,
  output logic                     ovf_evt,
  output logic                     unf_evt
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q, head_n, tail_n;
  logic              full_q, empty_q, full_a, empty_a, full_n, empty_n;
  logic              rd_ok, wr_ok;

  // Pop is resolved first; the push then sees the post-pop flags.
  always_comb begin
    rd_ok   = pop & ~empty_q;
    tail_n  = rd_ok ? tail_q + PTR_W'(1) : tail_q;
    full_a  = full_q & ~rd_ok;
    empty_a = empty_q | (rd_ok && (tail_q + PTR_W'(1)) == head_q);
    wr_ok   = push & ~full_a;
    head_n  = wr_ok ? head_q + PTR_W'(1) : head_q;
    empty_n = empty_a & ~wr_ok;
    full_n  = full_a | (wr_ok && head_n == tail_n);
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[head_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      full_q  <= full_n;
      empty_q <= empty_n;
    end
  end

  assign rd_data = mem[tail_q];
  assign head    = head_q;
  assign tail    = tail_q;
  assign full    = full_q;
  assign empty   = empty_q;
  assign ovf_evt = push & full_a;
  assign unf_evt = pop & empty_q;

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));
  assert_single_pop_R6: assert property (@(posedge clk) disable iff (rst)
    pop |=> !pop);
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (push && full_q && !pop) |=> ($stable(head_q) && full_q));
  assert_underflow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (pop && empty_q && !push) |=> ($stable(tail_q) && $stable(head_q) && empty_q));
endmodule

// File: rtl/adcseq_noise.sv
module adcseq_noise
  import adcseq_pkg::*;
#(
  parameter int unsigned SEQ_N  = 4,
  parameter int unsigned DATA_W = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SEQ_N-1:0]              accept,
  output logic [SEQ_N-1:0][DATA_W-1:0]  sample
);
  logic [31:0]              noise_q;
  logic [SEQ_N:0][31:0]     chain;
  logic [SEQ_N-1:0][31:0]   step;

  assign chain[0] = noise_q;

  for (genvar n = 0; n < SEQ_N; n++) begin : g_step
    assign step[n]      = lcg_next(chain[n]);
    assign chain[n+1]   = accept[n] ? step[n] : chain[n];
    assign sample[n]    = DATA_W'(SAMPLE_BASE + {29'd0, step[n][18:16]});
  end

  always_ff @(posedge clk) begin
    if (rst) noise_q <= '0;
    else     noise_q <= chain[SEQ_N];
  end

  assert_noise_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(|accept) |=> $stable(noise_q));
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int unsigned SEQ_N  = 4,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SEQ_N-1:0]  trig,
  output logic [SEQ_N-1:0]  irq
);
  localparam int unsigned PTR_W  = $clog2(DEPTH);
  localparam int unsigned IDX_W  = (SEQ_N > 1) ? $clog2(SEQ_N) : 1;
  localparam int unsigned EVS_W  = EVT_W * SEQ_N;
  localparam int unsigned WIN_END = WIN_BASE + WIN_SPAN * SEQ_N;

  logic [SEQ_N-1:0] act_q, raw_q, mask_q, ovf_q, unf_q, irq_q;
  logic [SEQ_N-1:0] raw_n, mask_n;
  logic [EVS_W-1:0] evsel_q;
  logic [31:0]      prio_q, avg_q, rdata_q, rd_mux;
  logic [31:0]      mux_q  [SEQ_N];
  logic [31:0]      ctrl_q [SEQ_N];
  logic             rd_prev_q, rd_fire;

  logic             win_hit;
  logic [ADDR_W-1:0] win_off;
  logic [IDX_W-1:0] win_idx;
  logic [4:0]       win_sub;

  logic [SEQ_N-1:0]              accept, pop, ovf_evt, unf_evt, f_full, f_empty;
  logic [SEQ_N-1:0][DATA_W-1:0]  sample, f_data;
  logic [SEQ_N-1:0][PTR_W-1:0]   f_head, f_tail;

  // Register-bus address decode
  assign win_hit = (32'(bus_addr) >= WIN_BASE) && (32'(bus_addr) < WIN_END);
  assign win_off = bus_addr - ADDR_W'(WIN_BASE);
  assign win_idx = win_off[5 +: IDX_W];
  assign win_sub = win_off[4:0];
  assign rd_fire = bus_rd & ~rd_prev_q;

  function automatic logic gwr(input logic wr, input logic hit,
                               input logic [ADDR_W-1:0] a, input int unsigned off);
    return wr && !hit && (32'(a) == off);
  endfunction

  // Trigger qualification and pop requests
  for (genvar n = 0; n < SEQ_N; n++) begin : g_seq
    assign accept[n] = trig[n] && act_q[n] &&
                       (32'(evsel_q[EVT_W*n +: EVT_W]) == EVT_CODE);
    assign pop[n]    = rd_fire && win_hit && (32'(win_idx) == n) &&
                       (32'(win_sub) == SUB_DATA);

    adcseq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .push     (accept[n]),
      .push_data(sample[n]),
      .pop      (pop[n]),
      .rd_data  (f_data[n]),
      .head     (f_head[n]),
      .tail     (f_tail[n]),
      .full     (f_full[n]),
      .empty    (f_empty[n]),
      .ovf_evt  (ovf_evt[n]),
      .unf_evt  (unf_evt[n])
    );

    assert_raw_needs_trigger_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(raw_q[n]) |-> $past(trig[n] && act_q[n]));
  end

  adcseq_noise #(.SEQ_N(SEQ_N), .DATA_W(DATA_W)) u_noise (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .sample(sample)
  );

  // Next raw/mask values so the interrupt line moves with them
  always_comb begin
    raw_n  = raw_q;
    mask_n = mask_q;
    if (gwr(bus_wr, win_hit, bus_addr, OFF_RAW))  raw_n = raw_q & ~bus_wdata[SEQ_N-1:0];
    raw_n = raw_n | accept;
    if (gwr(bus_wr, win_hit, bus_addr, OFF_MASK)) mask_n = bus_wdata[SEQ_N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      raw_q     <= '0;
      mask_q    <= '0;
      ovf_q     <= '0;
      unf_q     <= '0;
      irq_q     <= '0;
      evsel_q   <= '0;
      prio_q    <= '0;
      avg_q     <= '0;
      rd_prev_q <= 1'b0;
      for (int n = 0; n < SEQ_N; n++) begin
        mux_q[n]  <= '0;
        ctrl_q[n] <= '0;
      end
    end else begin
      rd_prev_q <= bus_rd;
      raw_q     <= raw_n;
      mask_q    <= mask_n;
      irq_q     <= raw_n & mask_n;
      if (gwr(bus_wr, win_hit, bus_addr, OFF_ENABLE)) act_q <= bus_wdata[SEQ_N-1:0];
      if (gwr(bus_wr, win_hit, bus_addr, OFF_EVSEL))  evsel_q <= bus_wdata[EVS_W-1:0];
      if (gwr(bus_wr, win_hit, bus_addr, OFF_PRIO))   prio_q <= bus_wdata;
      if (gwr(bus_wr, win_hit, bus_addr, OFF_AVG))    avg_q <= bus_wdata;
      if (gwr(bus_wr, win_hit, bus_addr, OFF_OVF))
        ovf_q <= (ovf_q & ~bus_wdata[SEQ_N-1:0]) | ovf_evt;
      else
        ovf_q <= ovf_q | ovf_evt;
      if (gwr(bus_wr, win_hit, bus_addr, OFF_UNF))
        unf_q <= (unf_q & ~bus_wdata[SEQ_N-1:0]) | unf_evt;
      else
        unf_q <= unf_q | unf_evt;
      for (int n = 0; n < SEQ_N; n++) begin
        if (bus_wr && win_hit && (32'(win_idx) == n)) begin
          if (32'(win_sub) == SUB_MUX)  mux_q[n]  <= bus_wdata & MUX_KEEP;
          if (32'(win_sub) == SUB_CTRL) ctrl_q[n] <= bus_wdata;
        end
      end
    end
  end

  // Read multiplexer
  always_comb begin
    rd_mux = '0;
    if (win_hit) begin
      case (32'(win_sub))
        SUB_MUX:   rd_mux = mux_q[win_idx];
        SUB_CTRL:  rd_mux = ctrl_q[win_idx];
        SUB_DATA:  rd_mux = 32'(f_data[win_idx]);
        SUB_STATE: rd_mux = 32'({f_empty[win_idx], f_full[win_idx],
                                 f_head[win_idx], f_tail[win_idx]});
        default:   rd_mux = '0;
      endcase
    end else begin
      case (32'(bus_addr))
        OFF_ENABLE: rd_mux = 32'(act_q);
        OFF_RAW:    rd_mux = 32'(raw_q);
        OFF_MASK:   rd_mux = 32'(mask_q);
        OFF_MSTAT:  rd_mux = 32'(raw_q & mask_q);
        OFF_OVF:    rd_mux = 32'(ovf_q);
        OFF_EVSEL:  rd_mux = 32'(evsel_q);
        OFF_UNF:    rd_mux = 32'(unf_q);
        OFF_PRIO:   rd_mux = prio_q;
        OFF_AVG:    rd_mux = avg_q;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q == (raw_q & mask_q));
  assert_read_once_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && rd_prev_q) |-> !(|pop));
endmodule

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  trig = '0;
  logic [3:0]  irq;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig(trig), .irq(irq)
  );

  // Scoreboard queues
  logic [31:0] q_exp [$];
  bit          q_chk [$];
  string       q_tag [$];

  // Bench model
  logic [31:0] m_noise = '0;
  logic [11:0] m_mem [4][16];
  int          m_head [4], m_tail [4], m_cnt [4];
  logic [3:0]  m_act = '0, m_raw = '0, m_ovf = '0, m_unf = '0;
  logic [31:0] m_evsel = '0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: samples the read word after the accepted rising edge
  logic tb_prev = 1'b0, seen = 1'b0;
  always @(posedge clk) begin
    seen    <= bus_rd && !tb_prev && !rst;
    tb_prev <= bus_rd;
  end
  always @(negedge clk) begin
    if (seen && q_exp.size() > 0) begin
      logic [31:0] e; bit c; string t;
      e = q_exp.pop_front(); c = q_chk.pop_front(); t = q_tag.pop_front();
      if (c) check(t, bus_rdata, e);
    end
  end

  function automatic logic [31:0] st(input int n);
    return 32'((m_cnt[n] == 0) << 9) | 32'((m_cnt[n] == 16) << 8) |
           32'(m_head[n] << 4) | 32'(m_tail[n]);
  endfunction

  function automatic logic [31:0] wadr(input int n, input int sub);
    return 32'h40 + 32 * n + sub;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd_hold(input logic [11:0] a, input logic [31:0] e, input bit c,
                         input string t, input int cyc);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    q_exp.push_back(e); q_chk.push_back(c); q_tag.push_back(t);
    repeat (cyc) @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    rd_hold(a, e, 1'b1, t, 1);
  endtask

  task automatic model_trig(input logic [3:0] m);
    for (int n = 0; n < 4; n++) begin
      if (m[n] && m_act[n] && m_evsel[4*n +: 4] == 4'd5) begin
        m_noise = m_noise * 32'd314159 + 32'd1;
        m_raw[n] = 1'b1;
        if (m_cnt[n] == 16) m_ovf[n] = 1'b1;
        else begin
          m_mem[n][m_head[n]] = 12'h200 + {9'd0, m_noise[18:16]};
          m_head[n] = (m_head[n] + 1) % 16; m_cnt[n]++;
        end
      end
    end
  endtask

  task automatic trg(input logic [3:0] m);
    @(negedge clk); trig = m; model_trig(m);
    @(negedge clk); trig = '0;
  endtask

  // Pop from model: returns expected data and whether it is defined
  task automatic mpop(input int n, output logic [31:0] e, output bit c);
    if (m_cnt[n] == 0) begin m_unf[n] = 1'b1; e = '0; c = 1'b0; end
    else begin
      e = 32'(m_mem[n][m_tail[n]]); c = 1'b1;
      m_tail[n] = (m_tail[n] + 1) % 16; m_cnt[n]--;
    end
  endtask

  task automatic rd_data(input int n, input string t);
    logic [31:0] e; bit c;
    mpop(n, e, c);
    rd_hold(wadr(n, 8)[11:0], e, c, t, 1);
  endtask

  task automatic drain;
    while (q_exp.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 4; n++) begin m_head[n] = 0; m_tail[n] = 0; m_cnt[n] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", 32'(irq), 0);
    for (int n = 0; n < 4; n++) rd(wadr(n, 12)[11:0], 32'h200, "R1 R2 empty state word");
    rd(12'h004, 0, "R1 raw after reset");
    rd(12'h000, 0, "R1 enable after reset");

    // R3: triggers ignored while disabled or on a wrong source code
    wr(12'h014, 32'h5555); m_evsel = 32'h5555;
    trg(4'hF);
    rd(wadr(0, 12)[11:0], st(0), "R3 disabled trigger ignored");
    rd(12'h004, 0, "R3 raw untouched");
    wr(12'h000, 32'hFFFF_FFFF); m_act = 4'hF;
    rd(12'h000, 32'hF, "R11 enable keeps 4 bits");
    wr(12'h014, 32'h5455); m_evsel = 32'h5455;
    trg(4'b0100);
    rd(wadr(2, 12)[11:0], st(2), "R3 wrong source ignored");
    wr(12'h014, 32'h5555); m_evsel = 32'h5555;

    // R4/R9/R10: samples, raw, mask, clear
    repeat (3) trg(4'b0001);
    rd(wadr(0, 12)[11:0], st(0), "R2 state after three pushes");
    rd(12'h004, 32'(m_raw), "R9 raw set");
    drain;
    check("R9 irq masked off", 32'(irq), 0);
    wr(12'h008, 32'hF);
    check("R9 irq follows mask", 32'(irq), 32'h1);
    wr(12'h004, 32'h1); m_raw[0] = 1'b0;
    check("R10 irq after raw clear", 32'(irq), 0);
    rd(12'h004, 32'(m_raw), "R10 raw cleared");

    // R4: same-cycle triggers step the noise in index order
    trg(4'b0011);
    rd_data(1, "R4 ordered noise seq1");
    rd(12'h00C, 32'(m_raw & 4'hF), "R9 masked status");
    drain;
    check("R9 irq lines", 32'(irq), 32'(m_raw));
    wr(12'h004, 32'hF); m_raw = '0;

    // R5/R6: reads, held read
    rd_data(0, "R5 first sample");
    rd_data(0, "R5 second sample");
    begin
      logic [31:0] e; bit c;
      mpop(0, e, c);
      rd_hold(wadr(0, 8)[11:0], e, c, "R6 held read one pop", 4);
    end
    rd(wadr(0, 12)[11:0], st(0), "R6 one pointer step");
    rd_data(0, "R5 last sample");
    rd(wadr(0, 12)[11:0], st(0), "R5 empty flag");

    // R7: underflow
    rd_data(0, "R7 underflow read");
    rd(12'h018, 32'(m_unf), "R7 underflow bit");
    rd(wadr(0, 12)[11:0], st(0), "R7 state unchanged");
    wr(12'h018, 32'h1); m_unf = '0;
    rd(12'h018, 0, "R10 underflow cleared");

    // R8: overflow on sequencer 3
    repeat (17) trg(4'b1000);
    rd(wadr(3, 12)[11:0], st(3), "R8 full state");
    rd(12'h010, 32'(m_ovf), "R8 overflow bit");
    for (int k = 0; k < 16; k++) rd_data(3, "R8 R5 drain after overflow");
    rd(wadr(3, 12)[11:0], st(3), "R5 wrapped empty state");
    wr(12'h010, 32'h8); m_ovf = '0;
    rd(12'h010, 0, "R10 overflow cleared");

    // R10: set beats clear
    wr(12'h004, 32'hF); m_raw = '0;
    @(negedge clk); trig = 4'b0010; bus_wr = 1'b1; bus_addr = 12'h004; bus_wdata = 32'h2;
    model_trig(4'b0010);
    @(negedge clk); trig = '0; bus_wr = 1'b0;
    rd(12'h004, 32'(m_raw), "R10 set wins over clear");

    // R11/R12: storage and windows
    wr(wadr(1, 0)[11:0], 32'hFFFF_FFFF);
    rd(wadr(1, 0)[11:0], 32'h3333_3333, "R11 mux mask");
    rd(wadr(0, 0)[11:0], 0, "R12 window separation");
    wr(wadr(3, 4)[11:0], 32'h0000_1234);
    rd(wadr(3, 4)[11:0], 32'h0000_1234, "R12 control at +4");
    wr(12'h020, 32'h3210);
    rd(12'h020, 32'h3210, "R11 priority readback");
    wr(12'h030, 32'h6);
    rd(12'h030, 32'h6, "R11 averaging readback");
    drain;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule